// File: doc/BRIEF.md
# Fuse Configuration Store with Readback Lock

This block keeps the configuration image of a programmable logic array: 5828 functional fuse bits, a 64-bit user signature placed directly after them, and one security bit. A host reaches every bit through a single addressed request port. Each request either reads one bit, writes one bit, sets the security bit, or runs a full erase. The erase clears the whole image one storage word per cycle and is the only way to release the security bit, so programming always begins with an erase.

The security bit guards the functional image. While it is set, functional reads come back as zero with a denied flag, and every write is refused. The signature is the exception: its eight bytes (for example an identifier or a revision code) stay readable at all times. Addresses past the end of the image are refused. Requests that arrive while an erase is running are dropped without a response.

Top module: `cfg_fuse_ctrl`

## Requirements
- R1: After reset, locked_o is 1, busy_o and ack_o are 0, and every bit of the image holds 0.
- R2: A read (op_i = 0) of a functional address (0 to 5827) while locked responds with rdata_o = 0, denied_o = 1 and reject_o = 0.
- R3: A read of a signature address (5828 to 5891) returns the stored bit with denied_o = 0, whether or not the block is locked.
- R4: A write (op_i = 1) to any address while locked responds with reject_o = 1 and leaves the image unchanged.
- R5: An erase (op_i = 3) holds busy_o high for exactly ceil(5892 / 32) = 185 cycles. Its ack_o arrives in the cycle busy_o falls. It leaves every bit at 0 and locked_o at 0. Nothing else clears locked_o.
- R6: While unlocked, a write to an in-range address stores wdata_i at that single bit, with reject_o = 0. A later read returns the most recent value written there, and neighbouring bits are not changed.
- R7: A read or write at an address of 5892 or above responds with reject_o = 1, rdata_o = 0 and denied_o = 0, and changes nothing.
- R8: A lock request (op_i = 2) is acknowledged with reject_o = 0, and locked_o reads 1 from the cycle of that acknowledgement.
- R9: A request presented while busy_o is high is dropped. It produces no ack_o and has no effect on the image.
- R10: Every accepted read, write or lock request produces exactly one ack_o, in the cycle after it is accepted, and responses come back in request order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when busy_o is low |
| op_i | input | 2 | 0 read, 1 write, 2 lock, 3 erase |
| addr_i | input | 13 | Bit address in the image |
| wdata_i | input | 1 | Bit value for a write |
| ack_o | output | 1 | Response valid, one cycle wide |
| rdata_o | output | 1 | Read bit, 0 when denied or refused |
| denied_o | output | 1 | Functional read refused by the lock |
| reject_o | output | 1 | Request refused: out of range, or a write while locked |
| busy_o | output | 1 | Erase in progress |
| locked_o | output | 1 | Security bit |

## Verification
The properties assume the host behaves in two ways. It presents at most one request per cycle, and it only expects a response for a request seen while busy_o was low. Requests during an erase are therefore legal input, but they must be silently discarded. The stimulus waits for busy_o to fall after each erase before it continues. The one deliberate exception is a single write pushed into the middle of an erase, which has no expected response and must leave no trace in the image. The addresses cover both ends of each region, runs of adjacent bits within one storage word, and values past the end of the image up to the largest 13-bit address.

// File: rtl/cfg_fuse_pkg.sv
package cfg_fuse_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_LOCK  = 2'd2,
    OP_ERASE = 2'd3
  } fuse_op_e;

  typedef struct packed {
    logic rdata;
    logic denied;
    logic reject;
  } fuse_rsp_t;
endpackage

// File: rtl/cfg_fuse_decode.sv
module cfg_fuse_decode #(
  parameter int FUNC_BITS = 5828,
  parameter int SIG_BITS  = 64,
  parameter int ADDR_W    = 13,
  parameter int WORD_W    = 32,
  parameter int WIDX_W    = 8,
  localparam int BIDX_W   = $clog2(WORD_W),
  localparam int TOTAL_BITS = FUNC_BITS + SIG_BITS
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WIDX_W-1:0] word_o,
  output logic [BIDX_W-1:0] bit_o,
  output logic              in_range_o,
  output logic              is_func_o
);
  assign in_range_o = addr_i < ADDR_W'(TOTAL_BITS);
  assign is_func_o  = addr_i < ADDR_W'(FUNC_BITS);
  // out-of-range addresses map to word 0 so the array index stays legal
  assign word_o = in_range_o ? WIDX_W'(addr_i >> BIDX_W) : '0;
  assign bit_o  = addr_i[BIDX_W-1:0];
endmodule

// File: rtl/cfg_fuse_array.sv
module cfg_fuse_array #(
  parameter int NUM_WORDS = 185,
  parameter int WORD_W    = 32,
  parameter int WIDX_W    = 8,
  localparam int BIDX_W   = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WIDX_W-1:0] wr_word_i,
  input  logic [BIDX_W-1:0] wr_bit_i,
  input  logic              wr_data_i,
  input  logic              clr_en_i,
  input  logic [WIDX_W-1:0] clr_word_i,
  input  logic [WIDX_W-1:0] rd_word_i,
  input  logic [BIDX_W-1:0] rd_bit_i,
  output logic              rd_bit_o
);
  logic [WORD_W-1:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '0;
    end else begin
      if (clr_en_i) mem_q[clr_word_i] <= '0;
      if (wr_en_i)  mem_q[wr_word_i][wr_bit_i] <= wr_data_i;
    end
  end

  assign rd_bit_o = mem_q[rd_word_i][rd_bit_i];

  assert_clear_excludes_write_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni) clr_en_i |-> !wr_en_i
  ) else $error("write collided with erase sweep");
endmodule

// File: rtl/cfg_erase_seq.sv
module cfg_erase_seq #(
  parameter int NUM_WORDS = 185,
  parameter int WIDX_W    = 8,
  localparam int LAST     = NUM_WORDS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              clr_en_o,
  output logic [WIDX_W-1:0] clr_word_o,
  output logic              done_o
);
  logic              busy_q;
  logic [WIDX_W-1:0] cnt_q;

  assign done_o = busy_q && (cnt_q == WIDX_W'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done_o) busy_q <= 1'b0;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign clr_en_o   = busy_q;
  assign clr_word_o = cnt_q;

  assert_sweep_in_bounds_R5: assert property (
    @(posedge clk_i) disable iff (!rst_ni) busy_q |-> (cnt_q <= WIDX_W'(LAST))
  ) else $error("erase index beyond last word");

  assert_done_ends_sweep_R5: assert property (
    @(posedge clk_i) disable iff (!rst_ni) done_o |=> !busy_q
  ) else $error("erase did not end after last word");
endmodule

// File: rtl/cfg_fuse_ctrl.sv
module cfg_fuse_ctrl
  import cfg_fuse_pkg::*;
#(
  parameter int FUNC_BITS = 5828,
  parameter int SIG_BITS  = 64,
  parameter int ADDR_W    = 13,
  parameter int WORD_W    = 32,
  localparam int TOTAL_BITS = FUNC_BITS + SIG_BITS,
  localparam int NUM_WORDS  = (TOTAL_BITS + WORD_W - 1) / WORD_W,
  localparam int WIDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int BIDX_W     = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  output logic              ack_o,
  output logic              rdata_o,
  output logic              denied_o,
  output logic              reject_o,
  output logic              busy_o,
  output logic              locked_o
);
  fuse_op_e          op;
  logic              busy, accept, wr_en, start, seq_done;
  logic              in_range, is_func, rd_bit;
  logic [WIDX_W-1:0] word, clr_word;
  logic [BIDX_W-1:0] bit_idx;
  logic              clr_en;
  logic              lock_q, ack_q;
  fuse_rsp_t         rsp_q, rsp_d;

  assign op     = fuse_op_e'(op_i);
  assign accept = req_i && !busy;
  assign start  = accept && (op == OP_ERASE);
  assign wr_en  = accept && (op == OP_WRITE) && in_range && !lock_q;

  cfg_fuse_decode #(
    .FUNC_BITS(FUNC_BITS), .SIG_BITS(SIG_BITS), .ADDR_W(ADDR_W),
    .WORD_W(WORD_W), .WIDX_W(WIDX_W)
  ) u_decode (
    .addr_i(addr_i), .word_o(word), .bit_o(bit_idx),
    .in_range_o(in_range), .is_func_o(is_func)
  );

  cfg_erase_seq #(.NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W)) u_erase (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .busy_o(busy),
    .clr_en_o(clr_en), .clr_word_o(clr_word), .done_o(seq_done)
  );

  cfg_fuse_array #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_word_i(word), .wr_bit_i(bit_idx), .wr_data_i(wdata_i),
    .clr_en_i(clr_en), .clr_word_i(clr_word),
    .rd_word_i(word), .rd_bit_i(bit_idx), .rd_bit_o(rd_bit)
  );

  always_comb begin
    rsp_d = '0;
    unique case (op)
      OP_READ: begin
        rsp_d.reject = !in_range;
        rsp_d.denied = in_range && is_func && lock_q;
        rsp_d.rdata  = in_range && !(is_func && lock_q) && rd_bit;
      end
      OP_WRITE: rsp_d.reject = !in_range || lock_q;
      default:  rsp_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;  // blank part powers up secured until erased
      ack_q  <= 1'b0;
      rsp_q  <= '0;
    end else begin
      ack_q <= (accept && (op != OP_ERASE)) || seq_done;
      rsp_q <= accept ? rsp_d : '0;
      if (accept && (op == OP_LOCK)) lock_q <= 1'b1;
      else if (seq_done)             lock_q <= 1'b0;
    end
  end

  assign ack_o    = ack_q;
  assign rdata_o  = rsp_q.rdata;
  assign denied_o = rsp_q.denied;
  assign reject_o = rsp_q.reject;
  assign busy_o   = busy;
  assign locked_o = lock_q;

  assert_ack_next_cycle_R10: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
      (req_i && !busy_o && (op_i != 2'd3)) |=> ack_o
  ) else $error("accepted request not acknowledged next cycle");

  assert_denied_reads_zero_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
      (ack_o && denied_o) |-> (!rdata_o && !reject_o)
  ) else $error("denied read leaked data");

  assert_locked_write_refused_R4: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
      (req_i && !busy_o && (op_i == 2'd1) && locked_o) |=> (ack_o && reject_o)
  ) else $error("write accepted while locked");

  assert_unlock_only_by_erase_R5: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
      $fell(locked_o) |-> (ack_o && $past(busy_o))
  ) else $error("lock released outside erase");

  assert_no_ack_while_busy_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni) busy_o |-> !ack_o
  ) else $error("response during erase");
endmodule

// File: tb/cfg_fuse_ctrl_bench.sv
module cfg_fuse_ctrl_bench;
  localparam int FUNC = 5828;
  localparam int SIG  = 64;
  localparam int TOT  = FUNC + SIG;
  localparam int ERASE_CYC = (TOT + 31) / 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [12:0] addr = '0;
  logic        wdata = 1'b0;
  logic        ack, rdata, denied, reject, busy, locked;

  int          n_vec = 0;
  int          n_bad = 0;
  logic [TOT-1:0] model = '0;
  logic        lock_m = 1'b1;
  logic [2:0]  exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cfg_fuse_ctrl u_cfg_fuse_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .denied_o(denied),
    .reject_o(reject), .busy_o(busy), .locked_o(locked)
  );

  task automatic check(string tag, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every response
  always @(negedge clk) begin
    if (rst_n && ack) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10: unexpected response actual %b%b%b expected none",
                 rdata, denied, reject);
      end else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rdata, denied, reject} !== e) begin
          n_bad++;
          $display("FAIL %s: actual rdata/denied/reject %b%b%b expected %b",
                   t, rdata, denied, reject, e);
        end
      end
    end
  end

  task automatic issue(logic [1:0] o, int a, logic d, string tag);
    logic rej, den, rd;
    logic in_r, fn;
    in_r = a < TOT;
    fn   = a < FUNC;
    rej = 1'b0; den = 1'b0; rd = 1'b0;
    case (o)
      2'd0: begin
        rej = !in_r;
        den = in_r && fn && lock_m;
        rd  = (in_r && !den) ? model[a] : 1'b0;
      end
      2'd1: begin
        rej = !in_r || lock_m;
        if (!rej) model[a] = d;
      end
      2'd2: lock_m = 1'b1;
      default: ;
    endcase
    exp_q.push_back({rd, den, rej});
    tag_q.push_back(tag);
    req = 1'b1; op = o; addr = 13'(a); wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic do_erase(bit inject);
    int cyc = 0;
    exp_q.push_back(3'b000);
    tag_q.push_back("R5");
    req = 1'b1; op = 2'd3; addr = '0; wdata = 1'b0;
    @(negedge clk);
    req = 1'b0;
    while (busy && cyc < 1000) begin
      cyc++;
      if (inject && cyc == 3) begin
        req = 1'b1; op = 2'd1; addr = 13'd5840; wdata = 1'b1;  // R9 dropped write
      end else req = 1'b0;
      @(negedge clk);
    end
    req = 1'b0;
    model = '0;
    lock_m = 1'b0;
    check("R5 busy cycles", (cyc == ERASE_CYC), 1'b1);
    check("R5 unlocked", locked, 1'b0);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int lfsr;
    int adr[24];
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 locked", locked, 1'b1);
    check("R1 busy", busy, 1'b0);
    check("R1 ack", ack, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(2'd0, 5828, 1'b0, "R1 R3 signature blank");
    issue(2'd0, 5891, 1'b0, "R3 last signature bit");
    issue(2'd0, 100, 1'b0, "R2 locked functional read");
    issue(2'd0, 5827, 1'b0, "R2 last functional bit");
    // R4: writes refused while locked
    issue(2'd1, 10, 1'b1, "R4 locked write");
    issue(2'd1, 5830, 1'b1, "R4 locked signature write");
    issue(2'd0, 5830, 1'b0, "R4 no effect");
    // R5 and R9: erase with a dropped request
    do_erase(1'b1);
    issue(2'd0, 5840, 1'b0, "R9 dropped write left no trace");
    issue(2'd0, 0, 1'b0, "R5 erased bit");
    // R6: scattered writes then readback
    lfsr = 32'h1d3;
    for (int i = 0; i < 20; i++) begin
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      adr[i] = lfsr % TOT;
    end
    adr[20] = 0; adr[21] = 5827; adr[22] = 5828; adr[23] = 5891;
    for (int i = 0; i < 24; i++) issue(2'd1, adr[i], 1'b1, "R6 write");
    for (int i = 0; i < 24; i++) issue(2'd0, adr[i], model[adr[i]], "R6 readback");
    // R6: alternating bits within one word, then overwrite
    for (int i = 64; i < 96; i++) issue(2'd1, i, 1'(i % 2), "R6 word pattern");
    issue(2'd1, 65, 1'b0, "R6 overwrite");
    for (int i = 63; i < 97; i++) issue(2'd0, i, 1'b0, "R6 word readback");
    // R7: out of range
    issue(2'd1, 5892, 1'b1, "R7 write past end");
    issue(2'd0, 5892, 1'b0, "R7 read past end");
    issue(2'd0, 8191, 1'b0, "R7 read max address");
    issue(2'd0, 5891, 1'b0, "R7 last bit untouched");
    // R8: lock
    issue(2'd2, 0, 1'b0, "R8 lock ack");
    check("R8 locked", locked, 1'b1);
    issue(2'd0, 5827, 1'b0, "R2 denied after lock");
    issue(2'd0, 80, 1'b0, "R2 denied after lock");
    issue(2'd0, 5828, 1'b0, "R3 signature after lock");
    issue(2'd0, 5891, 1'b0, "R3 signature after lock");
    issue(2'd1, 5829, 1'b1, "R4 write after lock");
    issue(2'd0, 5829, 1'b0, "R4 signature unchanged");
    // R5: second erase releases lock and clears image
    do_erase(1'b0);
    issue(2'd0, 5827, 1'b0, "R5 cleared functional");
    issue(2'd0, 5891, 1'b0, "R5 cleared signature");
    issue(2'd0, 81, 1'b0, "R5 cleared word");
    repeat (3) @(negedge clk);
    check("R10 responses drained", (exp_q.size() == 0), 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule